// File: doc/BRIEF.md
# Keyed 64-bit Watchdog Timer

This block is a 64-bit up-counter behind a small 32-bit register bus. Software loads the count, the 64-bit terminal value, a run mode and a global mode while the block is idle. It then writes an ordered pair of 16-bit keys to the watchdog control word to arm it. From that point every configuration word is frozen. Only a system reset brings the block back to idle.

Once armed, software has to keep writing the same key pair, in order, before the counter reaches the terminal value. The second key restarts the count from zero. If the count ever equals the terminal value while the block is armed and in watchdog mode, a sticky timeout flag is set. A reset-request output then pulses high for exactly one cycle, and the counter wraps to zero.

The bus is a single-cycle strobe with a write enable, a byte address and write data. Read data is combinational from the address. Accesses whose address bits [1:0] are not zero, or whose address lies above the register window, write nothing and read zero.

Top module: `keyed_wdog`

## Requirements
- R1: After reset every register reads zero except the identification word at byte offset 0x00, which reads the ID_VALUE parameter. The block is idle, and both the timeout flag and the reset-request output are low.
- R2: While idle, these writes are stored and read back:
  - the low and high terminal words at 0x18 and 0x1C, in full;
  - the run mode at 0x20, bits [7:6];
  - the release bits and the global mode at 0x24, bits [1:0] and [3:2].
  All other bits of these words read zero. Offsets 0x04, 0x08, 0x0C and 0x2C to 0x3C read zero.
- R3: The 64-bit counter reads live, with its low word at 0x10 and its high word at 0x14. While idle, a write to either word loads that word. The counter advances by one per cycle only when the run mode is 2 and both release bits are 1, and a carry out of the low word increments the high word. When it is running and equals the terminal value, it wraps to zero on the next edge.
- R4: A write of key 0xA5C6 in bits [31:16] of the control word at 0x28, with bit 14 set, moves the block from idle to a pre-armed state. A following 0xDA7E with bit 14 set moves it to armed. Other keys, or a key without bit 14, leave the state unchanged. Only reset returns the block to idle.
- R5: From the pre-armed state onward, writes to 0x10 through 0x24 are ignored. Bit 14 of the control word can no longer be changed.
- R6: While armed, 0xA5C6 enters a service state. There, 0xDA7E zeroes the counter and returns the block to armed, and any other key returns it to armed without touching the counter. A 0xDA7E received while armed without a preceding 0xA5C6 has no effect.
- R7: When the armed or service state holds, the global mode is 2, the counter is running and it equals the terminal value, the block times out. The timeout flag (control word bit 15) sets, and the reset-request output is high for one cycle, in the cycle after that edge. A zeroing 0xDA7E in the same cycle suppresses the timeout.
- R8: The timeout flag is cleared by writing 1 to bit 15 of the control word in any state, and is otherwise sticky. A timeout in the same cycle wins over the clear.
- R9: The control word reads bit 14 as the stored enable, bit 15 as the flag, and zero in bits [31:16] and in all other bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| wd_timeout | output | 1 | Sticky timeout flag |
| wd_rst_req | output | 1 | One-cycle reset-request pulse |

## Verification
The hardest situation to reach is a timeout whose compare spans both 32-bit words while the block is in the service state between the two keys, with a flag clear landing near the same edge. The stimulus loads the low count just below its carry point and sets the high terminal word to one before arming. After that, fixed-seed random traffic mixes complete and broken key pairs, stray keys, flag clears and locked configuration writes against short terminal values. Timeouts therefore fall in every state and at every spacing from a restart.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

   typedef enum logic [1:0] {
      WD_IDLE    = 2'd0,
      WD_PRE     = 2'd1,
      WD_ARMED   = 2'd2,
      WD_SERVICE = 2'd3
   } wd_state_e;

   localparam logic [15:0] KEY_OPEN  = 16'hA5C6;
   localparam logic [15:0] KEY_CLOSE = 16'hDA7E;

   // word indices (byte offset / 4)
   localparam logic [3:0] IX_IDENT  = 4'd0;
   localparam logic [3:0] IX_CNT_LO = 4'd4;
   localparam logic [3:0] IX_CNT_HI = 4'd5;
   localparam logic [3:0] IX_TRM_LO = 4'd6;
   localparam logic [3:0] IX_TRM_HI = 4'd7;
   localparam logic [3:0] IX_RUNCTL = 4'd8;
   localparam logic [3:0] IX_GLBCTL = 4'd9;
   localparam logic [3:0] IX_WDCTL  = 4'd10;

   localparam int EN_BIT   = 14;
   localparam int FLAG_BIT = 15;
   localparam int KEY_LSB  = 16;

   localparam logic [1:0] RUN_CONTINUOUS = 2'd2;
   localparam logic [1:0] GLB_WATCHDOG   = 2'd2;

endpackage

// File: rtl/wdog_keyfsm.sv
module wdog_keyfsm
   import wdog_pkg::*;
#(
   parameter int KEY_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             key_wr,
   input  logic [KEY_W-1:0] key,
   input  logic             en_in,
   output wd_state_e        state,
   output logic             restart
);

   initial begin
      if (KEY_W != 16) $error("wdog_keyfsm: KEY_W must be 16");
   end

   wd_state_e state_nx;

   always_comb begin
      state_nx = state;
      restart  = 1'b0;
      if (key_wr) begin
         unique case (state)
            WD_IDLE:    if (key == KEY_OPEN && en_in)  state_nx = WD_PRE;
            WD_PRE:     if (key == KEY_CLOSE && en_in) state_nx = WD_ARMED;
            WD_ARMED:   if (key == KEY_OPEN)           state_nx = WD_SERVICE;
            WD_SERVICE: begin
               state_nx = WD_ARMED;
               restart  = (key == KEY_CLOSE);
            end
            default:    state_nx = WD_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= WD_IDLE;
      else        state <= state_nx;
   end

endmodule

// File: rtl/wdog_cnt.sv
module wdog_cnt #(
   parameter int WORD_W = 32,
   parameter int CNT_W  = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              clr,
   input  logic [NWORD-1:0]  ld,
   input  logic [WORD_W-1:0] ld_data,
   input  logic [CNT_W-1:0]  term,
   output logic [CNT_W-1:0]  cnt,
   output logic              hit
);

   localparam int NWORD = CNT_W / WORD_W;

   initial begin
      if (CNT_W % WORD_W != 0) $error("wdog_cnt: CNT_W must be a multiple of WORD_W");
      if (NWORD < 1)           $error("wdog_cnt: at least one word required");
   end

   logic [NWORD:0] carry;
   logic           any_ld;
   logic           wrap;

   assign carry[0] = 1'b1;
   assign any_ld   = |ld;
   assign hit      = run && (cnt == term);
   assign wrap     = clr || hit;

   for (genvar g = 0; g < NWORD; g++) begin : g_word
      logic [WORD_W-1:0] w_q;

      assign carry[g+1]                 = carry[g] && (&w_q);
      assign cnt[g*WORD_W +: WORD_W]    = w_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            w_q <= '0;
         end else if (any_ld) begin
            if (ld[g]) w_q <= ld_data;
         end else if (wrap) begin
            w_q <= '0;
         end else if (run && carry[g]) begin
            w_q <= w_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
   import wdog_pkg::*;
#(
   parameter int          WORD_W   = 32,
   parameter int          CNT_W    = 64,
   parameter bit          HAS_ID   = 1'b1,
   parameter logic [31:0] ID_VALUE = 32'h5744_0001
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [3:0]        widx,
   input  logic              acc_ok,
   input  logic [WORD_W-1:0] wdata,
   input  logic              unlocked,
   input  logic              timeout,
   input  logic [CNT_W-1:0]  cnt,
   output logic [CNT_W-1:0]  term,
   output logic [1:0]        run_mode,
   output logic [1:0]        release_q,
   output logic [1:0]        glb_mode,
   output logic              en_q,
   output logic              flag_q,
   output logic [WORD_W-1:0] rdata
);

   initial begin
      if (WORD_W != 32)         $error("wdog_regs: WORD_W must be 32");
      if (CNT_W != 2 * WORD_W)  $error("wdog_regs: CNT_W must be two words");
   end

   logic [WORD_W-1:0] id_word;

   if (HAS_ID) begin : g_id
      assign id_word = ID_VALUE;
   end else begin : g_no_id
      assign id_word = '0;
   end

   logic cfg_wr;
   logic flag_clr;

   assign cfg_wr   = wr && unlocked;
   assign flag_clr = wr && (widx == IX_WDCTL) && wdata[FLAG_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         term      <= '0;
         run_mode  <= '0;
         release_q <= '0;
         glb_mode  <= '0;
         en_q      <= 1'b0;
      end else if (cfg_wr) begin
         unique case (widx)
            IX_TRM_LO: term[WORD_W-1:0]      <= wdata;
            IX_TRM_HI: term[CNT_W-1:WORD_W]  <= wdata;
            IX_RUNCTL: run_mode              <= wdata[7:6];
            IX_GLBCTL: begin
               release_q <= wdata[1:0];
               glb_mode  <= wdata[3:2];
            end
            IX_WDCTL:  en_q                  <= wdata[EN_BIT];
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag_q <= 1'b0;
      else if (timeout)  flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
   end

   always_comb begin
      rdata = '0;
      if (acc_ok) begin
         unique case (widx)
            IX_IDENT:  rdata = id_word;
            IX_CNT_LO: rdata = cnt[WORD_W-1:0];
            IX_CNT_HI: rdata = cnt[CNT_W-1:WORD_W];
            IX_TRM_LO: rdata = term[WORD_W-1:0];
            IX_TRM_HI: rdata = term[CNT_W-1:WORD_W];
            IX_RUNCTL: rdata[7:6] = run_mode;
            IX_GLBCTL: rdata[3:0] = {glb_mode, release_q};
            IX_WDCTL: begin
               rdata[EN_BIT]   = en_q;
               rdata[FLAG_BIT] = flag_q;
            end
            default:   rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
   import wdog_pkg::*;
#(
   parameter int          ADDR_W   = 6,
   parameter int          WORD_W   = 32,
   parameter bit          HAS_ID   = 1'b1,
   parameter logic [31:0] ID_VALUE = 32'h5744_0001
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_en,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              wd_timeout,
   output logic              wd_rst_req
);

   localparam int CNT_W = 2 * WORD_W;
   localparam int NWORD = CNT_W / WORD_W;
   localparam int KEY_W = WORD_W - KEY_LSB;

   initial begin
      if (ADDR_W < 6)    $error("keyed_wdog: ADDR_W must be at least 6");
      if (WORD_W != 32)  $error("keyed_wdog: WORD_W must be 32");
   end

   // ---------------- address decode ----------------
   logic       acc_ok;
   logic [3:0] widx;

   assign widx = bus_addr[5:2];

   if (ADDR_W == 6) begin : g_addr_exact
      assign acc_ok = (bus_addr[1:0] == 2'b00);
   end else begin : g_addr_wide
      assign acc_ok = (bus_addr[1:0] == 2'b00) && (bus_addr[ADDR_W-1:6] == '0);
   end

   logic reg_wr;
   logic key_wr;

   assign reg_wr = bus_en && bus_we && acc_ok;
   assign key_wr = reg_wr && (widx == IX_WDCTL);

   // ---------------- key sequencer ----------------
   wd_state_e wd_state;
   logic      restart;

   wdog_keyfsm #(.KEY_W(KEY_W)) u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .key_wr  (key_wr),
      .key     (bus_wdata[WORD_W-1:KEY_LSB]),
      .en_in   (bus_wdata[EN_BIT]),
      .state   (wd_state),
      .restart (restart)
   );

   logic unlocked;
   logic armed;

   assign unlocked = (wd_state == WD_IDLE);
   assign armed    = (wd_state == WD_ARMED) || (wd_state == WD_SERVICE);

   // ---------------- registers ----------------
   logic [CNT_W-1:0] term_q;
   logic [CNT_W-1:0] cnt_q;
   logic [1:0]       run_mode;
   logic [1:0]       release_q;
   logic [1:0]       glb_mode;
   logic             en_q;
   logic             flag_q;
   logic             timeout;

   wdog_regs #(
      .WORD_W   (WORD_W),
      .CNT_W    (CNT_W),
      .HAS_ID   (HAS_ID),
      .ID_VALUE (ID_VALUE)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (reg_wr),
      .widx      (widx),
      .acc_ok    (acc_ok),
      .wdata     (bus_wdata),
      .unlocked  (unlocked),
      .timeout   (timeout),
      .cnt       (cnt_q),
      .term      (term_q),
      .run_mode  (run_mode),
      .release_q (release_q),
      .glb_mode  (glb_mode),
      .en_q      (en_q),
      .flag_q    (flag_q),
      .rdata     (bus_rdata)
   );

   // ---------------- counter ----------------
   logic             run;
   logic             hit;
   logic [NWORD-1:0] cnt_ld;

   assign run       = (run_mode == RUN_CONTINUOUS) && (&release_q);
   assign cnt_ld[0] = reg_wr && unlocked && (widx == IX_CNT_LO);
   assign cnt_ld[1] = reg_wr && unlocked && (widx == IX_CNT_HI);

   wdog_cnt #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .clr     (restart),
      .ld      (cnt_ld),
      .ld_data (bus_wdata),
      .term    (term_q),
      .cnt     (cnt_q),
      .hit     (hit)
   );

   // ---------------- timeout ----------------
   assign timeout = hit && armed && (glb_mode == GLB_WATCHDOG) && !restart;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wd_rst_req <= 1'b0;
      else        wd_rst_req <= timeout;
   end

   assign wd_timeout = flag_q;

endmodule

// File: rtl/keyed_wdog_chk.sv
module keyed_wdog_chk
   import wdog_pkg::*;
#(
   parameter int ADDR_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_en,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input wd_state_e         state,
   input logic [63:0]       cnt,
   input logic [63:0]       term,
   input logic              flag,
   input logic              rst_req
);

   logic wctl_wr;
   assign wctl_wr = bus_en && bus_we &&
                    (bus_addr == ADDR_W'({IX_WDCTL, 2'b00}));

   // R4: armed states never fall back to idle without reset
   p_no_disarm_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state != WD_IDLE) |=> (state != WD_IDLE));

   // R5: terminal value frozen once out of idle
   p_term_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state != WD_IDLE) |=> $stable(term));

   // R6: closing key in service zeroes the count
   p_restart_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == WD_SERVICE && wctl_wr && bus_wdata[31:16] == KEY_CLOSE) |=> (cnt == '0));

   // R7: reset request only with flag set
   p_req_with_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> flag);

   // R7: reset request only after an armed cycle
   p_req_needs_arm_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> $past(state == WD_ARMED || state == WD_SERVICE));

   // R7: pulse is one cycle wide for a nonzero terminal value
   p_req_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_req && term != '0) |=> !rst_req);

   // R8: flag drops only on a write of one to bit 15
   p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag) |-> $past(wctl_wr && bus_wdata[FLAG_BIT]));

endmodule

bind keyed_wdog keyed_wdog_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_en    (bus_en),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .state     (wd_state),
   .cnt       (cnt_q),
   .term      (term_q),
   .flag      (flag_q),
   .rst_req   (wd_rst_req)
);

// File: tb/test_keyed_wdog.sv
module test_keyed_wdog;

   localparam logic [31:0] ID_V = 32'h5744_0001;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_en = 1'b0;
   logic        bus_we = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        wd_timeout;
   logic        wd_rst_req;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   keyed_wdog #(.ADDR_W(6), .ID_VALUE(ID_V)) i_keyed_wdog (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_en     (bus_en),
      .bus_we     (bus_we),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .wd_timeout (wd_timeout),
      .wd_rst_req (wd_rst_req)
   );

   // ---------------- reference model from the requirements ----------------
   logic [1:0]  m_state;
   logic [63:0] m_cnt, m_term;
   logic [1:0]  m_run, m_rel, m_glb;
   logic        m_en, m_flag, m_req;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_state <= 0; m_cnt <= 0; m_term <= 0; m_run <= 0; m_rel <= 0;
         m_glb <= 0; m_en <= 0; m_flag <= 0; m_req <= 0;
      end else begin
         logic w, running, hit, rs, to;
         logic [3:0] ix;
         logic [15:0] k;
         w  = bus_en && bus_we && bus_addr[1:0] == 2'b00;
         ix = bus_addr[5:2];
         k  = bus_wdata[31:16];
         running = (m_run == 2) && (m_rel == 3);
         hit = running && (m_cnt == m_term);
         rs  = w && ix == 10 && m_state == 3 && k == 16'hDA7E;
         to  = hit && m_glb == 2 && m_state >= 2 && !rs;
         if (m_state == 0 && w && ix == 4)      m_cnt[31:0]  <= bus_wdata;
         else if (m_state == 0 && w && ix == 5) m_cnt[63:32] <= bus_wdata;
         else if (rs || hit)                    m_cnt <= 0;
         else if (running)                      m_cnt <= m_cnt + 1;
         if (m_state == 0 && w) begin
            case (ix)
               6:  m_term[31:0]  <= bus_wdata;
               7:  m_term[63:32] <= bus_wdata;
               8:  m_run <= bus_wdata[7:6];
               9:  begin m_glb <= bus_wdata[3:2]; m_rel <= bus_wdata[1:0]; end
               10: m_en <= bus_wdata[14];
               default: ;
            endcase
         end
         if (to) m_flag <= 1'b1;
         else if (w && ix == 10 && bus_wdata[15]) m_flag <= 1'b0;
         m_req <= to;
         if (w && ix == 10) begin
            case (m_state)
               0: if (k == 16'hA5C6 && bus_wdata[14]) m_state <= 1;
               1: if (k == 16'hDA7E && bus_wdata[14]) m_state <= 2;
               2: if (k == 16'hA5C6) m_state <= 3;
               default: m_state <= 2;
            endcase
         end
      end
   end

   function automatic logic [31:0] exp_rd(int ix);
      case (ix)
         0:  return ID_V;
         4:  return m_cnt[31:0];
         5:  return m_cnt[63:32];
         6:  return m_term[31:0];
         7:  return m_term[63:32];
         8:  return {24'd0, m_run, 6'd0};
         9:  return {28'd0, m_glb, m_rel};
         10: return {16'd0, m_flag, m_en, 14'd0};
         default: return 32'd0;
      endcase
   endfunction

   function automatic string tag_of(int ix);
      case (ix)
         4, 5:        return "R3";
         6, 7, 8, 9:  return "R2";
         10:          return "R9";
         default:     return "R1";
      endcase
   endfunction

   // ---------------- bus tasks (start and end at a falling edge) ----------------
   task automatic wr(int ix, logic [31:0] d);
      bus_en = 1'b1; bus_we = 1'b1; bus_addr = 6'(ix << 2); bus_wdata = d;
      @(negedge clk);
      bus_en = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd_chk(int ix, string tag);
      logic [31:0] e;
      bus_en = 1'b1; bus_we = 1'b0; bus_addr = 6'(ix << 2);
      #1;
      e = exp_rd(ix);
      n_chk++;
      if (bus_rdata !== e) begin
         n_fail++;
         $display("FAIL %s: read idx %0d got %h expected %h", tag, ix, bus_rdata, e);
      end
      bus_en = 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      bus_en = 1'b0; bus_we = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // per-cycle output check: R7 pulse, R8 flag
   always @(negedge clk) begin
      if (rst_n && !done) begin
         n_chk++;
         if (wd_rst_req !== m_req) begin
            n_fail++;
            $display("FAIL R7: rst_req got %b expected %b at cycle %0d", wd_rst_req, m_req, cyc);
         end
         n_chk++;
         if (wd_timeout !== m_flag) begin
            n_fail++;
            $display("FAIL R8: flag got %b expected %b at cycle %0d", wd_timeout, m_flag, cyc);
         end
      end
   end

   // watchdog
   always @(negedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         done = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: run did not finish");
         $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd7321));
      do_reset();

      // R1: reset values
      for (int i = 0; i < 16; i++) rd_chk(i, "R1");

      // R2 / R9: idle writes read back with masking
      wr(8, 32'hFFFF_FFFF);
      wr(9, 32'hFFFF_FFFF);
      wr(10, 32'hFFFF_BFFF);
      rd_chk(8, "R2");
      rd_chk(9, "R2");
      rd_chk(10, "R9");
      wr(10, 32'h0000_4000);
      rd_chk(10, "R9");
      wr(6, 32'h0000_0005);
      wr(7, 32'h0000_0001);
      rd_chk(6, "R2");
      rd_chk(7, "R2");

      // R3: carry across the word boundary while idle
      wr(4, 32'hFFFF_FFFC);
      wr(5, 32'h0);
      wr(8, 32'h0000_0080);   // run mode 2
      wr(9, 32'h0000_000B);   // watchdog mode, both halves released
      idle(2);
      rd_chk(4, "R3");
      rd_chk(5, "R3");
      idle(3);
      rd_chk(4, "R3");
      rd_chk(5, "R3");

      // R4 / R5: first key locks configuration
      wr(10, 32'hA5C6_4000);
      wr(6, 32'h0000_0007);
      rd_chk(6, "R5");
      wr(10, 32'hDA7E_0000);   // no enable bit: stays pre-armed
      wr(10, 32'hDA7E_4000);   // armed
      wr(9, 32'h0);
      rd_chk(9, "R5");
      wr(10, 32'h0000_0000);   // enable cannot be cleared
      rd_chk(10, "R5");

      // R7: wait for the 64-bit compare to fire
      idle(12);
      rd_chk(10, "R7");
      rd_chk(4, "R7");

      // R8: flag clear
      wr(10, 32'h0000_8000);
      rd_chk(10, "R8");

      // R6: lone closing key ignored, full pair restarts
      idle(3);
      wr(10, 32'hDA7E_4000);
      rd_chk(4, "R6");
      wr(10, 32'hA5C6_4000);
      idle(2);
      wr(10, 32'hDA7E_4000);
      rd_chk(4, "R6");
      wr(10, 32'hA5C6_4000);
      wr(10, 32'h1234_4000);   // wrong key: back to armed, no restart
      rd_chk(4, "R6");
      wr(10, 32'hDA7E_4000);
      rd_chk(4, "R6");

      // random epochs
      for (int ep = 0; ep < 8; ep++) begin
         do_reset();
         wr(6, 32'd12 + ($urandom % 50));
         wr(7, 32'h0);
         wr(8, 32'h0000_0080);
         wr(9, 32'h0000_000B);
         if (ep != 7) begin
            wr(10, 32'hA5C6_4000);
            wr(10, 32'hDA7E_4000);
         end
         for (int op = 0; op < 400; op++) begin
            int r;
            r = $urandom % 100;
            if (r < 35) begin
               idle(1 + $urandom % 6);
            end else if (r < 60) begin
               wr(10, 32'hA5C6_0000 | ($urandom & 32'h0000_C000));
               idle($urandom % 3);
               wr(10, 32'hDA7E_0000 | ($urandom & 32'h0000_C000));
            end else if (r < 72) begin
               int s;
               s = $urandom % 3;
               wr(10, {(s == 0) ? 16'hA5C6 : (s == 1) ? 16'hDA7E : 16'($urandom),
                       16'($urandom)});
            end else if (r < 85) begin
               int ix;
               ix = 4 + $urandom % 6;
               wr(ix, (ix == 8) ? 32'h80 : (ix == 9) ? 32'hB : 32'($urandom % 40));
            end else begin
               @(negedge clk);
            end
            begin
               int ix;
               ix = $urandom % 16;
               rd_chk(ix, tag_of(ix));
            end
         end
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule